// File: doc/BRIEF.md
# Base-Limit Address Relocation and Protection Unit

This unit sits between a processor and its memory and gives a running user program a single contiguous window of physical memory. It holds one base register and one limit register. While the processor is in user mode, every logical address it presents is compared with the limit and offset by the base. Both operations run side by side in the same cycle. An address inside the window becomes a memory request one cycle later. An address beyond the window never reaches memory. Instead, the unit raises a one-cycle fault that carries the offending address, and it enters privileged mode at the same clock edge.

The unit also holds the processor's privilege bit. Privileged mode is entered on any trap (system call, interrupt or exception), and also on a fault. The only way back to user mode is an explicit resume command. In privileged mode, addresses pass to memory untouched and unchecked. Only privileged software may load the base and limit registers. A write attempted in user mode is discarded and flagged. Both registers are always visible on readback outputs, so a context switch can save the outgoing values before it loads new ones.

Top module: `relocation_guard`

## Requirements
- R1: After reset the unit is in privileged mode (priv_mode = 1), base_q and limit_q are zero, and mem_valid, fault_pulse and cfg_reject are low.
- R2: In user mode, a request whose logical address is less than or equal to limit_q produces mem_valid = 1 in the next cycle, with mem_addr equal to the zero-extended logical address plus base_q, taken modulo 2^PADDR_W.
- R3: In user mode, a request whose logical address is greater than limit_q produces no mem_valid. In the next cycle, fault_pulse is high for exactly one cycle and fault_addr holds the logical address.
- R4: The cycle in which fault_pulse is high is also the first cycle with priv_mode = 1, so the fault and the mode switch occur at the same clock edge.
- R5: In privileged mode, a request produces mem_valid in the next cycle with mem_addr equal to the zero-extended logical address, and it never faults, whatever the limit.
- R6: A configuration write in privileged mode loads base_q when cfg_sel = 0, or loads limit_q from the low LADDR_W bits of cfg_wdata when cfg_sel = 1. The new value is visible on the readback output in the next cycle.
- R7: A configuration write in user mode leaves base_q and limit_q unchanged, and it raises cfg_reject for one cycle in the next cycle.
- R8: A trap_in pulse puts the unit in privileged mode from the next cycle on, and it wins over a resume_user command in the same cycle.
- R9: A resume_user command in privileged mode, with no trap present, returns the unit to user mode in the next cycle. A fault in the same cycle as resume_user leaves the unit in privileged mode.
- R10: A logical address equal to limit_q is accepted, and the address one above it faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Address request present |
| req_addr | input | LADDR_W | Logical address |
| mem_valid | output | 1 | Memory access issued |
| mem_addr | output | PADDR_W | Physical address |
| fault_pulse | output | 1 | One-cycle addressing fault |
| fault_addr | output | LADDR_W | Logical address that faulted |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects base, 1 selects limit |
| cfg_wdata | input | PADDR_W | Register write data |
| cfg_reject | output | 1 | A user-mode write was discarded |
| base_q | output | PADDR_W | Base register readback |
| limit_q | output | LADDR_W | Limit register readback |
| trap_in | input | 1 | Trap, system call, interrupt or exception |
| resume_user | input | 1 | Return-to-user command |
| priv_mode | output | 1 | 1 = privileged, 0 = user |

## Verification
A mode change and an address request can land in the same cycle. The bench provokes this in three ways. It sends a user request beyond the limit together with resume_user. It sends a privileged request that is out of range for the limit together with resume_user. It sends a valid user request together with trap_in. In each case, the bench's reference model decides the outcome from the mode that was current when the request was presented. The fault, or the trap, must win the mode decision, and the scoreboard compares the issued address or the fault against the model.

// File: rtl/rlg_pkg.sv
package rlg_pkg;

  typedef enum logic {
    MODE_USER = 1'b0,
    MODE_PRIV = 1'b1
  } mode_e;

  typedef enum logic {
    SEL_BASE  = 1'b0,
    SEL_LIMIT = 1'b1
  } cfg_sel_e;

endpackage

// File: rtl/rlg_mode_ctl.sv
module rlg_mode_ctl
  import rlg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  trap_in,
  input  logic  fault_evt,
  input  logic  resume_user,
  output mode_e mode_q
);

  mode_e mode_d;

  // Entry to privileged mode outranks the resume command.
  always_comb begin
    mode_d = mode_q;
    if (trap_in || fault_evt) begin
      mode_d = MODE_PRIV;
    end else if (resume_user) begin
      mode_d = MODE_USER;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_PRIV;
    end else begin
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/rlg_bound_regs.sv
module rlg_bound_regs
  import rlg_pkg::*;
#(
  parameter int LADDR_W = 16,
  parameter int PADDR_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  mode_e              mode,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [PADDR_W-1:0] cfg_wdata,
  output logic [PADDR_W-1:0] base_q,
  output logic [LADDR_W-1:0] limit_q,
  output logic               reject_q
);

  logic               base_en;
  logic               limit_en;
  logic               reject_d;
  logic [PADDR_W-1:0] base_d;
  logic [LADDR_W-1:0] limit_d;

  // Register loads are gated by the mode current in the write cycle.
  always_comb begin
    base_en  = cfg_we && (mode == MODE_PRIV) && (cfg_sel_e'(cfg_sel) == SEL_BASE);
    limit_en = cfg_we && (mode == MODE_PRIV) && (cfg_sel_e'(cfg_sel) == SEL_LIMIT);
    reject_d = cfg_we && (mode == MODE_USER);
    base_d   = cfg_wdata;
    limit_d  = cfg_wdata[LADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
    end else if (limit_en) begin
      limit_q <= limit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reject_q <= 1'b0;
    end else begin
      reject_q <= reject_d;
    end
  end

endmodule

// File: rtl/rlg_xlate.sv
module rlg_xlate
  import rlg_pkg::*;
#(
  parameter int LADDR_W = 16,
  parameter int PADDR_W = 20
) (
  input  mode_e              mode,
  input  logic               req_valid,
  input  logic [LADDR_W-1:0] req_addr,
  input  logic [PADDR_W-1:0] base,
  input  logic [LADDR_W-1:0] limit,
  output logic               grant,
  output logic               fault_evt,
  output logic [PADDR_W-1:0] phys_addr
);

  logic [PADDR_W-1:0] ext_addr;
  logic [PADDR_W-1:0] reloc_sum;
  logic               over_limit;

  // Sum and compare are independent and evaluated side by side.
  always_comb begin
    ext_addr   = PADDR_W'(req_addr);
    reloc_sum  = ext_addr + base;
    over_limit = req_addr > limit;
  end

  always_comb begin
    if (mode == MODE_PRIV) begin
      phys_addr = ext_addr;
      grant     = req_valid;
      fault_evt = 1'b0;
    end else begin
      phys_addr = reloc_sum;
      grant     = req_valid && !over_limit;
      fault_evt = req_valid && over_limit;
    end
  end

endmodule

// File: rtl/relocation_guard.sv
module relocation_guard
  import rlg_pkg::*;
#(
  parameter int LADDR_W = 16,
  parameter int PADDR_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [LADDR_W-1:0] req_addr,
  output logic               mem_valid,
  output logic [PADDR_W-1:0] mem_addr,
  output logic               fault_pulse,
  output logic [LADDR_W-1:0] fault_addr,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [PADDR_W-1:0] cfg_wdata,
  output logic               cfg_reject,
  output logic [PADDR_W-1:0] base_q,
  output logic [LADDR_W-1:0] limit_q,
  input  logic               trap_in,
  input  logic               resume_user,
  output logic               priv_mode
);

  logic               rst_meta_n;
  logic               rst_sync_n;
  mode_e              mode_q;
  logic               grant;
  logic               fault_evt;
  logic [PADDR_W-1:0] phys_addr;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  rlg_mode_ctl u_mode (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .trap_in     (trap_in),
    .fault_evt   (fault_evt),
    .resume_user (resume_user),
    .mode_q      (mode_q)
  );

  rlg_bound_regs #(
    .LADDR_W (LADDR_W),
    .PADDR_W (PADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mode      (mode_q),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .base_q    (base_q),
    .limit_q   (limit_q),
    .reject_q  (cfg_reject)
  );

  rlg_xlate #(
    .LADDR_W (LADDR_W),
    .PADDR_W (PADDR_W)
  ) u_xlate (
    .mode      (mode_q),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .base      (base_q),
    .limit     (limit_q),
    .grant     (grant),
    .fault_evt (fault_evt),
    .phys_addr (phys_addr)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mem_valid   <= 1'b0;
      fault_pulse <= 1'b0;
    end else begin
      mem_valid   <= grant;
      fault_pulse <= fault_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mem_addr <= '0;
    end else if (grant) begin
      mem_addr <= phys_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      fault_addr <= '0;
    end else if (fault_evt) begin
      fault_addr <= req_addr;
    end
  end

  assign priv_mode = (mode_q == MODE_PRIV);

endmodule

// File: rtl/rlg_checker.sv
module rlg_checker #(
  parameter int LADDR_W = 16,
  parameter int PADDR_W = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [LADDR_W-1:0] req_addr,
  input logic               mem_valid,
  input logic [PADDR_W-1:0] mem_addr,
  input logic               fault_pulse,
  input logic [LADDR_W-1:0] fault_addr,
  input logic               cfg_we,
  input logic               cfg_reject,
  input logic [PADDR_W-1:0] base_q,
  input logic [LADDR_W-1:0] limit_q,
  input logic               trap_in,
  input logic               resume_user,
  input logic               priv_mode
);

  logic [PADDR_W-1:0] chk_sum;
  assign chk_sum = PADDR_W'(req_addr) + base_q;

  assert_user_reloc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !priv_mode && req_addr <= limit_q) |=> (mem_valid && mem_addr == $past(chk_sum)));

  assert_fault_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !priv_mode && req_addr > limit_q) |=> (fault_pulse && !mem_valid && fault_addr == $past(req_addr)));

  assert_fault_priv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> priv_mode);

  assert_priv_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && priv_mode) |=> (mem_valid && !fault_pulse && mem_addr == PADDR_W'($past(req_addr))));

  assert_reject_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !priv_mode) |=> (cfg_reject && $stable(base_q) && $stable(limit_q)));

  assert_trap_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_in |=> priv_mode);

  assert_user_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(priv_mode) |-> $past(resume_user && !trap_in));

endmodule

bind relocation_guard rlg_checker #(
  .LADDR_W (LADDR_W),
  .PADDR_W (PADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_addr    (req_addr),
  .mem_valid   (mem_valid),
  .mem_addr    (mem_addr),
  .fault_pulse (fault_pulse),
  .fault_addr  (fault_addr),
  .cfg_we      (cfg_we),
  .cfg_reject  (cfg_reject),
  .base_q      (base_q),
  .limit_q     (limit_q),
  .trap_in     (trap_in),
  .resume_user (resume_user),
  .priv_mode   (priv_mode)
);

// File: tb/sim_relocation_guard.sv
`timescale 1ns/1ps
module sim_relocation_guard;

  localparam int LW = 16;
  localparam int PW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [LW-1:0] req_addr = '0;
  logic          mem_valid;
  logic [PW-1:0] mem_addr;
  logic          fault_pulse;
  logic [LW-1:0] fault_addr;
  logic          cfg_we = 1'b0;
  logic          cfg_sel = 1'b0;
  logic [PW-1:0] cfg_wdata = '0;
  logic          cfg_reject;
  logic [PW-1:0] base_q;
  logic [LW-1:0] limit_q;
  logic          trap_in = 1'b0;
  logic          resume_user = 1'b0;
  logic          priv_mode;

  always #2.5 clk = ~clk;

  relocation_guard #(.LADDR_W(LW), .PADDR_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .fault_pulse(fault_pulse),
    .fault_addr(fault_addr), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_reject(cfg_reject), .base_q(base_q),
    .limit_q(limit_q), .trap_in(trap_in), .resume_user(resume_user),
    .priv_mode(priv_mode)
  );

  typedef struct {
    bit            is_fault;
    logic [PW-1:0] addr;
    string         tag;
  } exp_t;

  exp_t   sb_q[$];
  int     n_chk = 0;
  int     n_bad = 0;
  bit     done = 1'b0;
  bit     mon_on = 1'b0;

  // Reference model state
  bit            m_priv = 1'b1;
  logic [PW-1:0] m_base = '0;
  logic [LW-1:0] m_limit = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per output event
  always @(negedge clk) begin
    if (mon_on && (mem_valid || fault_pulse)) begin
      if (sb_q.size() == 0) begin
        chk("unexpected output", {fault_pulse, mem_valid}, 32'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (e.is_fault) begin
          chk({e.tag, " fault flag"}, {fault_pulse, mem_valid}, 32'h2);
          chk({e.tag, " fault addr"}, 32'(fault_addr), 32'(e.addr));
          chk({e.tag, " R4 priv with fault"}, 32'(priv_mode), 32'h1);
        end else begin
          chk({e.tag, " issue flag"}, {fault_pulse, mem_valid}, 32'h1);
          chk({e.tag, " phys addr"}, 32'(mem_addr), 32'(e.addr));
        end
      end
    end
  end

  // Driver: request, optionally with resume/trap in the same cycle
  task automatic do_req(input logic [LW-1:0] a, input bit rs, input bit tr, input string tag);
    exp_t e;
    e.tag = tag;
    if (m_priv) begin
      e.is_fault = 1'b0;
      e.addr = PW'(a);
      if (!tr && rs) m_priv = 1'b0;
    end else if (a > m_limit) begin
      e.is_fault = 1'b1;
      e.addr = PW'(a);
      m_priv = 1'b1;
    end else begin
      e.is_fault = 1'b0;
      e.addr = PW'(a) + m_base;
      if (tr) m_priv = 1'b1;
    end
    sb_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; resume_user = rs; trap_in = tr;
    @(posedge clk);
    #1;
    req_valid = 1'b0; resume_user = 1'b0; trap_in = 1'b0;
    chk({tag, " mode after request"}, 32'(priv_mode), 32'(m_priv));
  endtask

  task automatic do_mode(input bit rs, input bit tr, input string tag);
    if (tr) m_priv = 1'b1;
    else if (rs) m_priv = 1'b0;
    @(negedge clk);
    resume_user = rs; trap_in = tr;
    @(posedge clk);
    #1;
    resume_user = 1'b0; trap_in = 1'b0;
    chk({tag, " mode"}, 32'(priv_mode), 32'(m_priv));
  endtask

  task automatic do_cfg(input bit sel, input logic [PW-1:0] d, input string tag);
    bit was_priv;
    was_priv = m_priv;
    if (m_priv) begin
      if (sel) m_limit = d[LW-1:0];
      else     m_base = d;
    end
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    chk({tag, " reject flag"}, 32'(cfg_reject), was_priv ? 32'h0 : 32'h1);
    chk({tag, " base readback"}, 32'(base_q), 32'(m_base));
    chk({tag, " limit readback"}, 32'(limit_q), 32'(m_limit));
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset priv", 32'(priv_mode), 32'h1);
    chk("R1 reset base", 32'(base_q), 32'h0);
    chk("R1 reset limit", 32'(limit_q), 32'h0);
    chk("R1 reset outputs", {cfg_reject, fault_pulse, mem_valid}, 32'h0);
    mon_on = 1'b1;

    do_req(16'h1234, 1'b0, 1'b0, "R5 priv passthrough");
    do_cfg(1'b0, 20'h40000, "R6 load base");
    do_cfg(1'b1, 20'hA0FFF, "R6 load limit");
    do_mode(1'b1, 1'b0, "R9 resume to user");
    do_req(16'h0010, 1'b0, 1'b0, "R2 in range");
    do_req(16'h0FFF, 1'b0, 1'b0, "R10 equal to limit");
    do_req(16'h1000, 1'b0, 1'b0, "R10 R3 limit plus one");
    do_req(16'h8000, 1'b0, 1'b0, "R5 after fault unchecked");
    do_mode(1'b1, 1'b0, "R9 resume again");
    do_cfg(1'b0, 20'h12345, "R7 user base write");
    do_cfg(1'b1, 20'h0FFFF, "R7 user limit write");
    do_req(16'h0000, 1'b0, 1'b0, "R2 zero address");
    do_mode(1'b1, 1'b1, "R8 trap beats resume");
    do_mode(1'b1, 1'b0, "R9 resume");
    do_req(16'hF000, 1'b1, 1'b0, "R9 fault beats resume");
    do_req(16'hF000, 1'b1, 1'b0, "R5 priv with resume");
    do_req(16'h0100, 1'b0, 1'b1, "R8 user request with trap");
    do_cfg(1'b0, 20'hFFFF0, "R6 high base");
    do_cfg(1'b1, 20'h0FFFF, "R6 full limit");
    do_mode(1'b1, 1'b0, "R9 resume full");
    do_req(16'h0020, 1'b0, 1'b0, "R2 wrap");
    do_req(16'hFFFF, 1'b0, 1'b0, "R10 top address");
    repeat (3) @(posedge clk);
    #1;
    chk("scoreboard drained", 32'(sb_q.size()), 32'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

endmodule